// File: doc/BRIEF.md
# Oscillator Stabilization and PLL Power Supervisor

This block watches over an on-chip oscillator and the control bits of a PLL. After reset, or whenever the oscillator returns from power-down, it counts reference clock cycles. When the count reaches a parameterized settling length it raises a stable flag. Test mode or a counter-disable input can force the flag high at any time.

Software drives the block through one 8-bit control/status register. A power-down bit asks the oscillator to shut down. A mode bit selects when that happens: at once, or only when the clock generator reports that it has gone idle. Clearing the power-down bit before idle arrives cancels the request. The same register holds the PLL reset and PLL power-down controls. It also reports a lock flag from a simple delay model: lock drops while the PLL is held in reset or powered down, and returns a fixed number of cycles after both controls are released.

The counter lengths are parameters: `STABLE_COUNT` (41032 by default) and `LOCK_DELAY`.

Top module: `osc_supervisor`

## Requirements
- R1: Register layout. Bit 0 is the oscillator power-down request, bit 1 is PLL reset, bit 2 is PLL power-down and bit 3 is the immediate-mode bit; a write stores `wrData[3:0]` into these bits. Bits 5:4 read as zero, bit 6 reads the stable flag and bit 7 reads the lock flag. After reset the register reads 8'h02: PLL reset is set and every other bit is clear.
- R2: Apart from the override inputs, the stable flag is 0 until `STABLE_COUNT` clock edges have been counted after reset is released. It then stays 1.
- R3: The stable flag reads 1 in any cycle in which `testMode` or `cntDisable` is high, whatever the counter state.
- R4: With bit 0 and bit 3 both set, `oscPowerDown` goes high on the next clock edge.
- R5: With bit 0 set and bit 3 clear, `oscPowerDown` stays low until `idleIn` is high at a clock edge. It then rises on that edge and stays high while bit 0 remains set.
- R6: A deferred request is cancelled when bit 0 is cleared before idle: a later `idleIn` does not raise `oscPowerDown`.
- R7: Clearing bit 0 drops `oscPowerDown` on the next edge. It also restarts the stabilization counter from zero, so the stable flag is 0 until `STABLE_COUNT` counting edges have passed after power-down ends.
- R8: `pllReset` equals bit 1. While it is 1, the lock flag reads 0 from the next cycle on.
- R9: `pllPowerDown` equals bit 2. While it is 1, the lock flag reads 0 from the next cycle on.
- R10: Once bits 1 and 2 are both clear, the lock flag rises exactly `LOCK_DELAY` clock edges after the write that cleared them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 8 | Write data, bits 3:0 used |
| rdData | output | 8 | Control/status register read value |
| idleIn | input | 1 | Clock generator has entered idle |
| testMode | input | 1 | Test mode, forces stable flag |
| cntDisable | input | 1 | Stabilization counter disabled, forces stable flag |
| oscPowerDown | output | 1 | Oscillator power-down control |
| pllReset | output | 1 | PLL reset control |
| pllPowerDown | output | 1 | PLL power-down control |

## Verification
The bench builds the block with `STABLE_COUNT` = 20 and `LOCK_DELAY` = 6. These short windows put the exact edge on which stable rises, and the exact edge on which lock returns, within a directed test; each is checked one cycle early and on the cycle itself. The same settings make it cheap to rerun the settle window after a power-down exit, so the counter restart can be told apart from a counter that only paused. Short windows also let the immediate, deferred and cancelled power-down paths share one run.

// File: rtl/osc_sup_pkg.sv
package osc_sup_pkg;
  // Strobes from the control section to the counting datapath.
  typedef struct packed {
    logic oscCntClear;   // restart stabilization count
    logic lockCntClear;  // hold lock model at zero
  } strobe_t;

  localparam int REG_W = 8;
  localparam int BIT_OSC_OFF = 0;
  localparam int BIT_PLL_RST = 1;
  localparam int BIT_PLL_OFF = 2;
  localparam int BIT_IMM     = 3;
  localparam int BIT_STABLE  = 6;
  localparam int BIT_LOCKED  = 7;
endpackage

// File: rtl/osc_sup_counter.sv
module osc_sup_counter #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rstN,
  input  logic clear,
  output logic done
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt;

  assign done = (cnt == CW'(LIMIT));

  // Saturating up-counter; clear wins over counting.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      cnt <= '0;
    else if (clear) cnt <= '0;
    else if (!done) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/osc_sup_datapath.sv
module osc_sup_datapath
  import osc_sup_pkg::*;
#(
  parameter int STABLE_COUNT = 41032,
  parameter int LOCK_DELAY   = 64
) (
  input  logic    clk,
  input  logic    rstN,
  input  strobe_t strobes,
  output logic    oscDone,
  output logic    lockDone
);
  localparam int NUM_CNT = 2;
  localparam int LIMITS [NUM_CNT] = '{STABLE_COUNT, LOCK_DELAY};

  logic [NUM_CNT-1:0] clears;
  logic [NUM_CNT-1:0] dones;

  assign clears   = {strobes.lockCntClear, strobes.oscCntClear};
  assign oscDone  = dones[0];
  assign lockDone = dones[1];

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    osc_sup_counter #(.LIMIT(LIMITS[i])) u_cnt (
      .clk  (clk),
      .rstN (rstN),
      .clear(clears[i]),
      .done (dones[i])
    );
  end
endmodule

// File: rtl/osc_sup_control.sv
module osc_sup_control
  import osc_sup_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  input  logic             idleIn,
  input  logic             testMode,
  input  logic             cntDisable,
  input  logic             oscDone,
  input  logic             lockDone,
  output strobe_t          strobes,
  output logic [REG_W-1:0] rdData,
  output logic             oscPowerDown,
  output logic             pllReset,
  output logic             pllPowerDown
);
  logic oscOff, pllRst, pllOff, immMode;
  logic oscDown;
  logic oscOffFalling;
  logic stable;

  // Control bits; PLL reset comes out of reset asserted.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      oscOff  <= 1'b0;
      pllRst  <= 1'b1;
      pllOff  <= 1'b0;
      immMode <= 1'b0;
    end else if (wrEn) begin
      oscOff  <= wrData[BIT_OSC_OFF];
      pllRst  <= wrData[BIT_PLL_RST];
      pllOff  <= wrData[BIT_PLL_OFF];
      immMode <= wrData[BIT_IMM];
    end
  end

  // Power-down state: entered at once or on idle, held while requested,
  // dropped (or a pending request cancelled) once the request bit clears.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) oscDown <= 1'b0;
    else       oscDown <= oscOff && (oscDown || immMode || idleIn);
  end

  assign oscOffFalling = wrEn && oscOff && !wrData[BIT_OSC_OFF];

  always_comb begin
    strobes.oscCntClear  = oscDown || oscOffFalling;
    strobes.lockCntClear = pllRst || pllOff;
  end

  assign stable = oscDone || cntDisable || testMode;

  always_comb begin
    rdData              = '0;
    rdData[BIT_OSC_OFF] = oscOff;
    rdData[BIT_PLL_RST] = pllRst;
    rdData[BIT_PLL_OFF] = pllOff;
    rdData[BIT_IMM]     = immMode;
    rdData[BIT_STABLE]  = stable;
    rdData[BIT_LOCKED]  = lockDone;
  end

  assign oscPowerDown = oscDown;
  assign pllReset     = pllRst;
  assign pllPowerDown = pllOff;
endmodule

// File: rtl/osc_supervisor.sv
module osc_supervisor
  import osc_sup_pkg::*;
#(
  parameter int STABLE_COUNT = 41032,
  parameter int LOCK_DELAY   = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  input  logic       idleIn,
  input  logic       testMode,
  input  logic       cntDisable,
  output logic       oscPowerDown,
  output logic       pllReset,
  output logic       pllPowerDown
);
  strobe_t strobes;
  logic    oscDone;
  logic    lockDone;

  osc_sup_control u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .wrEn        (wrEn),
    .wrData      (wrData),
    .idleIn      (idleIn),
    .testMode    (testMode),
    .cntDisable  (cntDisable),
    .oscDone     (oscDone),
    .lockDone    (lockDone),
    .strobes     (strobes),
    .rdData      (rdData),
    .oscPowerDown(oscPowerDown),
    .pllReset    (pllReset),
    .pllPowerDown(pllPowerDown)
  );

  osc_sup_datapath #(
    .STABLE_COUNT(STABLE_COUNT),
    .LOCK_DELAY  (LOCK_DELAY)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .oscDone (oscDone),
    .lockDone(lockDone)
  );
endmodule

// File: rtl/osc_supervisor_checker.sv
module osc_supervisor_checker (
  input logic       clk,
  input logic       rstN,
  input logic [7:0] rdData,
  input logic       idleIn,
  input logic       testMode,
  input logic       cntDisable,
  input logic       oscPowerDown,
  input logic       pllReset,
  input logic       pllPowerDown
);
  p_override_r3: assert property (@(posedge clk) disable iff (!rstN)
    (testMode || cntDisable) |-> rdData[6]);

  p_imm_down_r4: assert property (@(posedge clk) disable iff (!rstN)
    (rdData[0] && rdData[3]) |=> oscPowerDown);

  p_defer_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!rdData[3] && !idleIn && !oscPowerDown) |=> !oscPowerDown);

  p_cancel_r6: assert property (@(posedge clk) disable iff (!rstN)
    !rdData[0] |=> !oscPowerDown);

  p_restart_r7: assert property (@(posedge clk) disable iff (!rstN)
    oscPowerDown |=> (rdData[6] == (testMode || cntDisable)));

  p_rst_unlock_r8: assert property (@(posedge clk) disable iff (!rstN)
    pllReset |=> !rdData[7]);

  p_off_unlock_r9: assert property (@(posedge clk) disable iff (!rstN)
    pllPowerDown |=> !rdData[7]);
endmodule

bind osc_supervisor osc_supervisor_checker u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .rdData      (rdData),
  .idleIn      (idleIn),
  .testMode    (testMode),
  .cntDisable  (cntDisable),
  .oscPowerDown(oscPowerDown),
  .pllReset    (pllReset),
  .pllPowerDown(pllPowerDown)
);

// File: tb/osc_supervisor_bench.sv
module osc_supervisor_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SC = 20;
  localparam int LD = 6;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic       idleIn = 1'b0;
  logic       testMode = 1'b0;
  logic       cntDisable = 1'b0;
  logic       oscPowerDown, pllReset, pllPowerDown;

  int nChecks = 0;
  int nFails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  osc_supervisor #(.STABLE_COUNT(SC), .LOCK_DELAY(LD)) u_osc_supervisor (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .idleIn(idleIn), .testMode(testMode), .cntDisable(cntDisable),
    .oscPowerDown(oscPowerDown), .pllReset(pllReset), .pllPowerDown(pllPowerDown)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    wrEn = 1'b1; wrData = d;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic t_reset_and_settle();
    rstN = 1'b0;
    tick(3);
    check("R1 reset value", rdData, 8'h02);
    check("R8 pllReset after reset", {7'd0, pllReset}, 8'h01);
    rstN = 1'b1;
    tick(SC - 1);
    check("R2 stable low before count", {7'd0, rdData[6]}, 8'h00);
    tick(1);
    check("R2 stable high at count", {7'd0, rdData[6]}, 8'h01);
    check("R1 bits 5:4 zero", {6'd0, rdData[5:4]}, 8'h00);
  endtask

  task automatic t_lock();
    wr(8'h00);
    check("R8 pllReset released", {7'd0, pllReset}, 8'h00);
    tick(LD - 1);
    check("R10 not locked one early", {7'd0, rdData[7]}, 8'h00);
    tick(1);
    check("R10 locked on time", {7'd0, rdData[7]}, 8'h01);
    wr(8'h04);
    check("R9 pllPowerDown set", {7'd0, pllPowerDown}, 8'h01);
    tick(1);
    check("R9 lock lost in power-down", {7'd0, rdData[7]}, 8'h00);
    wr(8'h00);
    tick(LD);
    check("R10 relock after power-up", {7'd0, rdData[7]}, 8'h01);
    wr(8'h02);
    tick(1);
    check("R8 lock lost in reset", {7'd0, rdData[7]}, 8'h00);
    wr(8'h00);
    tick(LD);
  endtask

  task automatic t_immediate();
    wr(8'h09);
    check("R1 readback", rdData & 8'h0F, 8'h09);
    tick(1);
    check("R4 immediate power-down", {7'd0, oscPowerDown}, 8'h01);
    tick(1);
    check("R7 stable cleared in power-down", {7'd0, rdData[6]}, 8'h00);
    testMode = 1'b1; #1;
    check("R3 testMode forces stable", {7'd0, rdData[6]}, 8'h01);
    testMode = 1'b0; cntDisable = 1'b1; #1;
    check("R3 cntDisable forces stable", {7'd0, rdData[6]}, 8'h01);
    cntDisable = 1'b0; #1;
    check("R3 no override", {7'd0, rdData[6]}, 8'h00);
    wr(8'h08);
    tick(1);
    check("R7 power-down exit", {7'd0, oscPowerDown}, 8'h00);
    tick(SC - 1);
    check("R7 stable low during restart", {7'd0, rdData[6]}, 8'h00);
    tick(1);
    check("R7 stable after restart", {7'd0, rdData[6]}, 8'h01);
  endtask

  task automatic t_deferred();
    wr(8'h01);
    tick(3);
    check("R5 waits for idle", {7'd0, oscPowerDown}, 8'h00);
    idleIn = 1'b1;
    tick(1);
    check("R5 down on idle", {7'd0, oscPowerDown}, 8'h01);
    idleIn = 1'b0;
    tick(2);
    check("R5 held after idle", {7'd0, oscPowerDown}, 8'h01);
    wr(8'h00);
    tick(1);
    check("R7 exit deferred", {7'd0, oscPowerDown}, 8'h00);
  endtask

  task automatic t_cancel();
    wr(8'h01);
    tick(2);
    wr(8'h00);
    idleIn = 1'b1;
    tick(2);
    check("R6 cancelled request", {7'd0, oscPowerDown}, 8'h00);
    idleIn = 1'b0;
  endtask

  initial begin
    fork
      begin
        t_reset_and_settle();
        t_lock();
        t_immediate();
        t_deferred();
        t_cancel();
      end
      begin
        repeat (20000) @(posedge clk);
        nChecks++; nFails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule